// File: doc/BRIEF.md
# Pointing-Device Serial Packet Receiver

This block listens to the two open-drain lines of a pointing device that reports movement on its own, without being polled. The device drives a slow serial clock and a data line. The receiver brings both lines into the system clock domain through a synchronizer. It filters short pulses off the serial clock and takes one data bit on each accepted falling edge. Thirty-three bits make one movement packet, sent as three 11-bit slices.

When the last bit of a packet arrives, the receiver checks the framing and the odd parity of each slice. It then shows the three payload bytes in the order they arrived, together with a one-cycle valid strobe and an error flag. A packet that stalls part way through is dropped after a programmable silence period. While the local transmitter holds the bus to send a command, the receiver ignores the lines and drops any packet it has partly collected. The receiver never drives the lines.

Top module: `ps2_mouse_rx`

## Requirements
- R1: After reset, `pkt_valid_o` and `pkt_err_o` are 0 and all three byte outputs are 0x00.
- R2: A packet is 33 bits received as three 11-bit slices. In each slice the first bit is the start bit, the next eight bits are the payload least significant bit first, then comes the parity bit, then the stop bit. The first slice's payload appears on `pkt_byte0_o`, the second on `pkt_byte1_o` and the third on `pkt_byte2_o`.
- R3: A data bit is taken from the synchronized data line on each accepted falling edge of the serial clock. Rising edges take no bit.
- R4: A slice whose eight payload bits plus parity bit hold an even number of ones is a parity failure.
- R5: A slice whose start bit is 1 or whose stop bit is 0 is a framing failure.
- R6: `pkt_err_o` is 1 in the strobe cycle exactly when at least one slice of that packet has a parity or framing failure. It is 0 in every cycle in which `pkt_valid_o` is 0.
- R7: The byte outputs change only in a cycle in which `pkt_valid_o` is 1, and otherwise hold their last values.
- R8: A low pulse on the serial clock shorter than `FILT_LEN` system cycles is not taken as an edge and adds no bit.
- R9: If no accepted falling edge arrives for `TIMEOUT_CYC` system cycles while a packet is partly received, the partial bits are discarded and the next bit starts a new packet.
- R10: While `host_busy_i` is 1, no bit is taken and any partly received packet is discarded. No strobe is raised in the cycle after a cycle with `host_busy_i` high.
- R11: `pkt_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_i | input | 1 | Serial clock line from the device, asynchronous |
| ps2_data_i | input | 1 | Serial data line from the device, asynchronous |
| host_busy_i | input | 1 | High while the local transmitter owns the bus |
| pkt_valid_o | output | 1 | One-cycle strobe for a complete packet |
| pkt_err_o | output | 1 | Framing or parity failure in the packet being strobed |
| pkt_byte0_o | output | 8 | Payload of the first slice |
| pkt_byte1_o | output | 8 | Payload of the second slice |
| pkt_byte2_o | output | 8 | Payload of the third slice |

## Verification
The hardest case to reach from the ports is a packet that stops part way and must be forgotten: a sender fault, a timeout, or the local transmitter taking the bus. A wrong receiver would not show this at once, only later, when the next packet's bytes come out misaligned. The stimulus therefore sends a deliberately truncated bit run, then lets the line fall silent past the timeout or raises the bus-busy input, and then sends a clean packet whose bytes must come out unshifted. Short spikes are placed in the high phase of the serial clock in the middle of a packet, so that a spike that is wrongly counted also misaligns the packet it sits in.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
    localparam int SLICE_BITS = 11;
    localparam int SLICES     = 3;
    localparam int FRAME_BITS = SLICE_BITS * SLICES;
    localparam int BYTE_BITS  = 8;

    typedef logic [SLICE_BITS-1:0] slice_t;

    // 1 when the slice has a bad start, a bad stop or even parity.
    function automatic logic slice_bad(input slice_t s);
        logic odd_ok;
        odd_ok = ^s[BYTE_BITS+1:1];
        return (s[0] != 1'b0) || (s[SLICE_BITS-1] != 1'b1) || !odd_ok;
    endfunction
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ps2_rx_filter.sv
module ps2_rx_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);
    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    typedef struct packed {
        logic          level;
        logic [CW-1:0] cnt;
        logic          fall;
    } filt_t;

    filt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        if (lvl_i == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(FILT_LEN-1)) begin
            s_d.level = lvl_i;
            s_d.cnt   = '0;
            s_d.fall  = !lvl_i;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{level: 1'b1, cnt: '0, fall: 1'b0};
        else        s_q <= s_d;
    end

    assign fall_o = s_q.fall;
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
    import ps2_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fall_i,
    input  logic                          data_i,
    input  logic                          block_i,
    output logic                          valid_o,
    output logic                          err_o,
    output logic [SLICES*BYTE_BITS-1:0]   bytes_o
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [FRAME_BITS-1:0]        sh;
        logic [BW-1:0]                cnt;
        logic [TW-1:0]                idle;
        logic                         valid;
        logic                         err;
        logic [SLICES*BYTE_BITS-1:0]  bytes;
    } frm_t;

    frm_t s_d, s_q;
    logic [FRAME_BITS-1:0] sh_next;
    logic                  any_bad;

    always_comb begin
        sh_next = {data_i, s_q.sh[FRAME_BITS-1:1]};
        any_bad = 1'b0;
        for (int k = 0; k < SLICES; k++) begin
            any_bad = any_bad | slice_bad(sh_next[k*SLICE_BITS +: SLICE_BITS]);
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.err   = 1'b0;
        if (block_i) begin
            s_d.cnt  = '0;
            s_d.idle = '0;
        end else if (fall_i) begin
            s_d.sh   = sh_next;
            s_d.idle = '0;
            if (s_q.cnt == BW'(FRAME_BITS-1)) begin
                s_d.cnt   = '0;
                s_d.valid = 1'b1;
                s_d.err   = any_bad;
                for (int k = 0; k < SLICES; k++) begin
                    s_d.bytes[k*BYTE_BITS +: BYTE_BITS] =
                        sh_next[k*SLICE_BITS+1 +: BYTE_BITS];
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (s_q.cnt != '0) begin
            if (s_q.idle == TW'(TIMEOUT_CYC-1)) begin
                s_d.cnt  = '0;
                s_d.idle = '0;
            end else begin
                s_d.idle = s_q.idle + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign err_o   = s_q.err;
    assign bytes_o = s_q.bytes;
endmodule

// File: rtl/ps2_mouse_rx.sv
module ps2_mouse_rx
    import ps2_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_data_i,
    input  logic       host_busy_i,
    output logic       pkt_valid_o,
    output logic       pkt_err_o,
    output logic [7:0] pkt_byte0_o,
    output logic [7:0] pkt_byte1_o,
    output logic [7:0] pkt_byte2_o
);
    logic clk_s, data_s, fall;
    logic [SLICES*BYTE_BITS-1:0] bytes;

    ps2_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_i(ps2_clk_i), .q_o(clk_s));

    ps2_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d_i(ps2_data_i), .q_o(data_s));

    ps2_rx_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .lvl_i(clk_s), .fall_o(fall));

    ps2_rx_frame #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .data_i(data_s),
        .block_i(host_busy_i), .valid_o(pkt_valid_o), .err_o(pkt_err_o),
        .bytes_o(bytes));

    assign pkt_byte0_o = bytes[0*BYTE_BITS +: BYTE_BITS];
    assign pkt_byte1_o = bytes[1*BYTE_BITS +: BYTE_BITS];
    assign pkt_byte2_o = bytes[2*BYTE_BITS +: BYTE_BITS];
endmodule

// File: rtl/ps2_mouse_rx_chk.sv
module ps2_mouse_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_busy_i,
    input logic       pkt_valid_o,
    input logic       pkt_err_o,
    input logic [7:0] pkt_byte0_o,
    input logic [7:0] pkt_byte1_o,
    input logic [7:0] pkt_byte2_o
);
    p_err_only_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err_o |-> pkt_valid_o);

    p_bytes_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid_o |-> $stable({pkt_byte2_o, pkt_byte1_o, pkt_byte0_o}));

    p_no_strobe_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_busy_i) |-> !pkt_valid_o);

    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |=> !pkt_valid_o);
endmodule

bind ps2_mouse_rx ps2_mouse_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_busy_i(host_busy_i),
    .pkt_valid_o(pkt_valid_o), .pkt_err_o(pkt_err_o),
    .pkt_byte0_o(pkt_byte0_o), .pkt_byte1_o(pkt_byte1_o),
    .pkt_byte2_o(pkt_byte2_o));

// File: tb/ps2_mouse_rx_bench.sv
module ps2_mouse_rx_bench;
    localparam int HALF    = 30;
    localparam int TIMEOUT = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps2_clk = 1'b1;
    logic ps2_data = 1'b1;
    logic busy = 1'b0;
    logic valid, err;
    logic [7:0] b0, b1, b2;

    int checks = 0;
    int fails  = 0;
    logic [24:0] expq[$];
    logic [23:0] last_bytes = '0;
    bit   done = 0;

    always #10 clk = ~clk;

    ps2_mouse_rx #(.SYNC_STAGES(2), .FILT_LEN(4), .TIMEOUT_CYC(TIMEOUT)) u_ps2_mouse_rx (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_data_i(ps2_data),
        .host_busy_i(busy), .pkt_valid_o(valid), .pkt_err_o(err),
        .pkt_byte0_o(b0), .pkt_byte1_o(b1), .pkt_byte2_o(b2));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: compared on every clock, away from the active edge.
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (valid) begin
                if (expq.size() == 0) begin
                    check("R2 unexpected strobe", 32'(valid), 32'd0);
                end else begin
                    logic [24:0] e;
                    e = expq.pop_front();
                    check("R2 bytes", {8'd0, b2, b1, b0}, {8'd0, e[23:0]});
                    check("R6 err flag", 32'(err), 32'(e[24]));
                end
                check("R11 strobe width", 32'(prev_valid), 32'd0);
                last_bytes = {b2, b1, b0};
            end else begin
                if (err !== 1'b0) check("R6 err without strobe", 32'(err), 32'd0);
                if ({b2, b1, b0} !== last_bytes)
                    check("R7 bytes hold", {8'd0, b2, b1, b0}, {8'd0, last_bytes});
            end
            prev_valid = valid;
        end
    end

    function automatic logic [10:0] mk_slice(input logic [7:0] d, input bit bad_par,
                                             input bit bad_start, input bit bad_stop);
        logic par;
        par = ~(^d) ^ bad_par;
        return {~bad_stop, par, d, bad_start};
    endfunction

    task automatic send_bit(input logic b, input bit glitch);
        ps2_data = b;
        repeat (HALF / 2) @(posedge clk);
        if (glitch) begin
            ps2_clk = 1'b0;
            repeat (2) @(posedge clk);
            ps2_clk = 1'b1;
        end
        repeat (HALF / 2) @(posedge clk);
        ps2_clk = 1'b0;
        repeat (HALF) @(posedge clk);
        ps2_clk = 1'b1;
    endtask

    task automatic send_bits(input logic [32:0] f, input int n, input int glitch_at);
        for (int i = 0; i < n; i++) send_bit(f[i], i == glitch_at);
        ps2_data = 1'b1;
    endtask

    task automatic send_pkt(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input bit e, input logic [32:0] f, input int glitch_at);
        expq.push_back({e, d2, d1, d0});
        send_bits(f, 33, glitch_at);
        repeat (40) @(posedge clk);
        check("R2 packet delivered", 32'(expq.size()), 32'd0);
    endtask

    task automatic good_pkt(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input int glitch_at);
        send_pkt(d0, d1, d2, 1'b0,
                 {mk_slice(d2,0,0,0), mk_slice(d1,0,0,0), mk_slice(d0,0,0,0)}, glitch_at);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R1 valid at reset", 32'(valid), 32'd0);
        check("R1 err at reset", 32'(err), 32'd0);
        check("R1 bytes at reset", {8'd0, b2, b1, b0}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);

        // R2 R3: plain packets, several data patterns
        good_pkt(8'h08, 8'h12, 8'hF3, -1);
        good_pkt(8'hFF, 8'h00, 8'hA5, -1);
        good_pkt(8'h01, 8'h80, 8'h5A, -1);

        // R4: parity failure in the middle slice
        send_pkt(8'h3C, 8'h77, 8'h10, 1'b1,
                 {mk_slice(8'h10,0,0,0), mk_slice(8'h77,1,0,0), mk_slice(8'h3C,0,0,0)}, -1);
        // R5: bad start in first slice, then bad stop in last slice
        send_pkt(8'h44, 8'h55, 8'h66, 1'b1,
                 {mk_slice(8'h66,0,0,0), mk_slice(8'h55,0,0,0), mk_slice(8'h44,0,1,0)}, -1);
        send_pkt(8'h9E, 8'h02, 8'hC1, 1'b1,
                 {mk_slice(8'hC1,0,0,1), mk_slice(8'h02,0,0,0), mk_slice(8'h9E,0,0,0)}, -1);
        // R6: clean packet after errors shows err low
        good_pkt(8'h2B, 8'hD0, 8'h7E, -1);

        // R8: short spikes in high phase inside the frame
        good_pkt(8'hE7, 8'h18, 8'h42, 5);
        good_pkt(8'h11, 8'h22, 8'h33, 20);

        // R9: truncated run, silence beyond timeout, then clean packet
        send_bits({22'h0, mk_slice(8'hAA,0,0,0)}, 14, -1);
        repeat (TIMEOUT + 200) @(posedge clk);
        check("R9 no strobe for partial", 32'(expq.size()), 32'd0);
        good_pkt(8'h6D, 8'hB2, 8'h0F, -1);

        // R10: partial run, bus taken, activity while busy, then clean packet
        send_bits({22'h0, mk_slice(8'h55,0,0,0)}, 12, -1);
        busy = 1'b1;
        repeat (20) @(posedge clk);
        send_bits({mk_slice(8'h01,0,0,0), mk_slice(8'h02,0,0,0), mk_slice(8'h03,0,0,0)}, 33, -1);
        repeat (20) @(posedge clk);
        busy = 1'b0;
        repeat (20) @(posedge clk);
        check("R10 no strobe while busy", 32'(expq.size()), 32'd0);
        good_pkt(8'hC3, 8'h3C, 8'h99, -1);

        repeat (50) @(posedge clk);
        check("R7 final bytes hold", {8'd0, b2, b1, b0}, {8'd0, 8'h99, 8'h3C, 8'hC3});
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule